// File: doc/BRIEF.md
# Automatic Conversion Interval Scheduler

This block sets the pace of an automatic sampling mode. It holds one 8-bit configuration byte. Software writes the byte and can read it back. The low three bits of the byte are an interval code. Code zero leaves automatic sampling off. Any other code makes the block issue a one-cycle conversion-start pulse at a fixed spacing. The spacing is a power-of-two multiple of a nominal conversion time, and the parameter `CONV_CYCLES` gives that time in clock cycles.

The two top bits of the byte are delay-enable controls. This block does not use them. It stores them and drives them out to a separate conversion sequencer. Writing a nonzero code restarts the interval count from zero, so software knows when the first pulse will arrive. Writing code zero stops the pulses at once.

Top module: `conv_interval_sched`

## Requirements
- R1: A write (`cfg_we` high at a rising edge) stores `cfg_wdata`. From the next cycle, `cfg_rdata` returns the written value with bits 5..3 forced to 0.
- R2: Bits 5..3 of `cfg_rdata` always read 0, whatever value was written to them.
- R3: After synchronous reset, `cfg_rdata` is 0x00, both delay outputs are 0, and `conv_start` stays low.
- R4: While the interval code (bits 2..0) is 000, `conv_start` never rises.
- R5: Codes 1 through 7 set the pulse spacing to `CONV_CYCLES` × 32, 64, 128, 256, 512, 1024 and 2048 cycles, in that order. In general the spacing is `CONV_CYCLES` × 2^(code+4).
- R6: `sample_dly_en` follows stored bit 7 and `trial_dly_en` follows stored bit 6.
- R7: A write with a nonzero code restarts the count. This holds even when the code is unchanged. The first pulse is high in the cycle that follows the rising edge one full interval after the write edge.
- R8: Each `conv_start` pulse lasts exactly one clock cycle.
- R9: A write of code 000 stops pulse generation immediately. No pulse follows that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (registered) |
| sample_dly_en | output | 1 | Stored sample-delay control (bit 7) |
| trial_dly_en | output | 1 | Stored bit-trial-delay control (bit 6) |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
The hardest case to reach is a rewrite that lands in the middle of an interval that is already running. The first pulse after it must be timed from the rewrite and not from the earlier write. The bench sets this up on purpose. It writes a code, lets part of the interval pass, then writes the same code again and measures the gap from the second write. It also writes code zero partway through an interval and watches well past the point where the old pulse would have come. Random bytes cover the readback masking and the delay bits. Each random byte that carries a short enough code also gets its first-pulse spacing measured.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned BIT_SMPDLY = 7;
  localparam int unsigned BIT_TRLDLY = 6;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'hC7;
  localparam int unsigned BASE_SHIFT = 4;
  localparam int unsigned MAX_MULT   = 2048;

  function automatic logic [31:0] interval_of(input int unsigned conv,
                                              input logic [CODE_W-1:0] code);
    return 32'(conv) << (32'(code) + 32'(BASE_SHIFT));
  endfunction
endpackage

// File: rtl/conv_cfg_reg.sv
module conv_cfg_reg
  import conv_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CFG_W-1:0]  rdata,
  output logic [CODE_W-1:0] code,
  output logic              smp_dly,
  output logic              trl_dly
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata & CFG_MASK;
  end

  assign rdata   = cfg_q;
  assign code    = cfg_q[CODE_W-1:0];
  assign smp_dly = cfg_q[BIT_SMPDLY];
  assign trl_dly = cfg_q[BIT_TRLDLY];

  // R1: readback of the written value, masked
  a_r1_readback: assert property (@(posedge clk) disable iff (rst)
    we |=> rdata == ($past(wdata) & CFG_MASK));
  // R2: unused bits never read as one
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[5:3] == 3'b000);
endmodule

// File: rtl/conv_interval_timer.sv
module conv_interval_timer
  import conv_sched_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] code,
  output logic              pulse
);
  localparam int unsigned MAX_IV = CONV_CYCLES * MAX_MULT;
  localparam int unsigned CW     = $clog2(MAX_IV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] iv_last;

  assign iv_last = CW'(interval_of(CONV_CYCLES, code) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (wr || code == '0) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (cnt_q == iv_last) begin
      cnt_q <= '0;
      pulse <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      pulse <= 1'b0;
    end
  end

  // R8: a pulse is never followed by another pulse
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  // R4: no pulse comes out of a disabled mode
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (code == '0 && !wr) |=> !pulse);
  // R9: a write of code zero allows no pulse after it
  a_r9_stop_now: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_code == '0) |=> !pulse);
  // R7: a nonzero write restarts the count
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_code != '0) |=> (cnt_q == '0 && !pulse));
endmodule

// File: rtl/conv_interval_sched.sv
module conv_interval_sched
  import conv_sched_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       sample_dly_en,
  output logic       trial_dly_en,
  output logic       conv_start
);
  logic [CODE_W-1:0] code;

  conv_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .code    (code),
    .smp_dly (sample_dly_en),
    .trl_dly (trial_dly_en)
  );

  conv_interval_timer #(.CONV_CYCLES(CONV_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_we),
    .wr_code (cfg_wdata[CODE_W-1:0]),
    .code    (code),
    .pulse   (conv_start)
  );

  // R6: delay outputs track the stored byte
  a_r6_delay_bits: assert property (@(posedge clk) disable iff (rst)
    sample_dly_en == cfg_rdata[7] && trial_dly_en == cfg_rdata[6]);
endmodule

// File: tb/conv_interval_sched_tb.sv
module conv_interval_sched_tb_top;
  localparam int unsigned CONV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       sample_dly_en, trial_dly_en, conv_start;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  conv_interval_sched #(.CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sample_dly_en(sample_dly_en),
    .trial_dly_en(trial_dly_en), .conv_start(conv_start)
  );

  function automatic int unsigned exp_interval(input logic [2:0] c);
    return (c == 3'd0) ? 0 : CONV * (32'd1 << (32'(c) + 4));
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [7:0] d);
    return {d[7:6], 3'b000, d[2:0]};
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // count negedges until conv_start is seen, 0 means already high
  task automatic wait_pulse(input int unsigned limit, output int unsigned k);
    k = 0;
    while (!conv_start && k <= limit) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic count_pulses(input int unsigned cycles, output int unsigned n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (conv_start) n++;
    end
  endtask

  initial begin
    int unsigned k, n, iv;
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    check("R3 rdata", cfg_rdata, 0);
    check("R3 delay", {sample_dly_en, trial_dly_en}, 0);
    count_pulses(200, n);
    check("R3 no pulse", n, 0);

    // R5/R7/R8 code 1 directed
    wr(8'h01);
    iv = exp_interval(3'd1);
    wait_pulse(2*iv, k);
    check("R7 first gap code1", k, iv);
    @(negedge clk);
    check("R8 width", conv_start, 0);
    wait_pulse(2*iv, k);
    check("R5 period code1", k + 1, iv);

    // R7 restart with same code mid-interval
    repeat (50) @(negedge clk);
    wr(8'h01);
    wait_pulse(2*iv, k);
    check("R7 restart gap", k, iv);

    // R9 stop mid-interval
    repeat (30) @(negedge clk);
    wr(8'h00);
    count_pulses(3*iv, n);
    check("R9 stopped", n, 0);

    // R2 unused bits, R6 delay bits
    wr(8'hFF);
    check("R2 mask", cfg_rdata, 8'hC7);
    check("R6 delays", {sample_dly_en, trial_dly_en}, 2'b11);
    wr(8'h38);
    check("R2 only unused", cfg_rdata, 0);
    count_pulses(3*exp_interval(3'd1), n);
    check("R4 code0 quiet", n, 0);

    // R5 code 7 directed (longest)
    wr(8'h47);
    iv = exp_interval(3'd7);
    check("R6 trial only", {sample_dly_en, trial_dly_en}, 2'b01);
    wait_pulse(2*iv, k);
    check("R5 code7 gap", k, iv);

    // random bytes
    for (int r = 0; r < 14; r++) begin
      d = 8'($urandom);
      wr(d);
      check("R1 readback", cfg_rdata, exp_rdata(d));
      check("R6 random delays", {sample_dly_en, trial_dly_en}, d[7:6]);
      iv = exp_interval(d[2:0]);
      if (d[2:0] == 3'd0) begin
        count_pulses(300, n);
        check("R4 random off", n, 0);
      end else if (d[2:0] <= 3'd5) begin
        wait_pulse(2*iv, k);
        check("R5 random gap", k, iv);
        @(negedge clk);
        check("R8 random width", conv_start, 0);
      end
    end
    wr(8'h00);
    done = 1'b1;
  end

  initial begin
    int unsigned c = 0;
    while (!done && c < 190000) begin
      @(negedge clk); c++;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", c);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule